// File: doc/BRIEF.md
# Cascadable presettable binary counter

The block is a synchronous binary up-counter, four bits wide by default, with a parallel preset, an active-low clear that acts on the clock edge, and two separate count enables. Every change of state happens on the rising clock edge. An edge first checks the clear, then the preset, then the count, and holds the value when none of them applies.

A terminal-count flag goes high when the carry-in enable is high and the count is all ones. No register sits on the flag's path, so it can drive the carry-in enable of the next stage directly. When the parallel enables of all stages are tied to one common enable, a chain of stages behaves as one wide counter, and every stage steps on the same edge. The flag stays high for one clock period each time the count passes its top value.

Top module: `presettable_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the levels of `load_n`, `din`, `en_par` and `en_carry`.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `din` after that edge, whatever the levels of both count enables.
- R3: When `clr_n`, `load_n`, `en_par` and `en_carry` are all high at a rising edge, `count` increases by one after that edge.
- R4: When `clr_n` and `load_n` are high and either `en_par` or `en_carry` is low at a rising edge, `count` keeps its value.
- R5: An increment from all ones (15 at the default width) gives 0. For example, a preset to 12 followed by four counting edges reads 12, 13, 14, 15, 0.
- R6: `tc` is high exactly when `en_carry` is high and `count` is all ones. `en_par` has no effect on it, and it follows a change of `en_carry` within the same cycle, with no clock edge in between.
- R7: A chain of stages in which each stage's `tc` drives the next stage's `en_carry`, and all `en_par` inputs share one enable, steps through all 2^(4N) values in order, without skipping, while the enable is high.
- R8: While the counter runs freely, `tc` is high for exactly one clock period per wrap: for the cycle in which `count` is all ones, and for no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr_n | input | 1 | Clear, active low, sampled on the clock edge, highest priority |
| load_n | input | 1 | Parallel preset enable, active low |
| din | input | WIDTH | Value copied into the count on a preset |
| en_par | input | 1 | Parallel count enable |
| en_carry | input | 1 | Carry-in count enable; also gates the terminal-count flag |
| count | output | WIDTH | Current count value |
| tc | output | 1 | Terminal-count flag, combinational |

## Verification
The count is the block's only state and appears directly on `count`. A wrong next value, such as a missed priority, a lost carry or a hold that leaks an increment, is therefore visible on the port after the edge where it happens and is compared there. A fault in the carry look-ahead only shows at the upper bits, so long runs that pass every bit transition, together with a three-stage chain covering all 4096 states, bring it out within one wrap of the affected stage. A fault in the flag gating shows without any clock edge when `en_carry` or `en_par` is toggled while the count sits at all ones.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Action taken at a rising edge, listed in priority order
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } pcnt_op_e;

endpackage

// File: rtl/pcnt_decode.sv
module pcnt_decode
    import pcnt_pkg::*;
(
    input  logic     clr_n,
    input  logic     load_n,
    input  logic     en_par,
    input  logic     en_carry,
    output pcnt_op_e op
);

    // Clear beats preset, preset beats count; hold is the fallback
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_carry) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/pcnt_incr.sv
module pcnt_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] plus_one,
    output logic             all_ones
);

    // Each bit gets its own wide AND of all lower bits (look-ahead carry)
    logic [WIDTH-1:0] low_ones;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign low_ones[i] = &value[i:0];
        if (i == 0) begin : g_lsb
            assign plus_one[i] = ~value[i];
        end else begin : g_upper
            assign plus_one[i] = value[i] ^ low_ones[i-1];
        end
    end

    assign all_ones = low_ones[WIDTH-1];

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_carry,
    output logic [WIDTH-1:0] count,
    output logic             tc
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    pcnt_op_e         op;
    logic [WIDTH-1:0] incr_value;
    logic             at_top;

    pcnt_decode u_decode (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_par   (en_par),
        .en_carry (en_carry),
        .op       (op)
    );

    pcnt_incr #(
        .WIDTH (WIDTH)
    ) u_incr (
        .value    (state_q.value),
        .plus_one (incr_value),
        .all_ones (at_top)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.value = ZERO;
            OP_LOAD:  state_d.value = din;
            OP_COUNT: state_d.value = incr_value;
            OP_HOLD:  state_d.value = state_q.value;
            default:  state_d.value = state_q.value;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.value;
    // No register on this path, so chained stages step on the same edge
    assign tc    = en_carry & at_top;

endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_carry,
    input logic [WIDTH-1:0] count,
    input logic             tc
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Checks start once a clear has been seen; before that the count is unknown
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= (armed_q === 1'b1) | ~clr_n;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        !clr_n |=> (count == '0)); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clr_n && !load_n) |=> (count == $past(din))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clr_n && load_n && en_par && en_carry) |=> (count == $past(count) + ONE)); // R3

    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clr_n && load_n && !(en_par && en_carry)) |=> $stable(count)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (tc && en_par && clr_n && load_n) |=> (count == '0)); // R5

    AST_TC_NEEDS_CARRY: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        tc |-> en_carry); // R6

    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (tc && en_par && clr_n && load_n) |=> !tc); // R8

endmodule

bind presettable_counter pcnt_checker #(
    .WIDTH (WIDTH)
) u_pcnt_checker (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .din      (din),
    .en_par   (en_par),
    .en_carry (en_carry),
    .count    (count),
    .tc       (tc)
);

// File: tb/pcnt_chain.sv
module pcnt_chain #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 4
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic                    load_n,
    input  logic [STAGES*WIDTH-1:0] din,
    input  logic                    en,
    output logic [STAGES*WIDTH-1:0] value,
    output logic                    tc_out
);

    logic [STAGES:0] link;

    assign link[0] = en;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        presettable_counter #(
            .WIDTH (WIDTH)
        ) u_stage (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .din      (din[s*WIDTH +: WIDTH]),
            .en_par   (en),
            .en_carry (link[s]),
            .count    (value[s*WIDTH +: WIDTH]),
            .tc       (link[s+1])
        );
    end

    assign tc_out = link[STAGES];

endmodule

// File: tb/test_presettable_counter.sv
`timescale 1ns/1ps
module test_presettable_counter;

    localparam int  W      = 4;
    localparam int  STAGES = 3;
    localparam int  CW     = STAGES * W;
    localparam real HALF   = 2.5;

    logic         clk = 1'b0;
    logic         clr_n, load_n, en_par, en_carry;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         tc;

    logic          ch_clr_n, ch_load_n, ch_en;
    logic [CW-1:0] ch_din, ch_value;
    logic          ch_tc;

    int n_checks = 0;
    int n_errors = 0;
    logic [W-1:0] exp_cnt;

    always #(HALF) clk = ~clk;

    presettable_counter #(.WIDTH(W)) i_presettable_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_carry(en_carry), .count(count), .tc(tc)
    );

    pcnt_chain #(.STAGES(STAGES), .WIDTH(W)) i_chain (
        .clk(clk), .clr_n(ch_clr_n), .load_n(ch_load_n), .din(ch_din),
        .en(ch_en), .value(ch_value), .tc_out(ch_tc)
    );

    function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c_n, logic l_n,
                                                logic [W-1:0] d, logic ep, logic ec);
        if (!c_n)           return '0;
        else if (!l_n)      return d;
        else if (ep && ec)  return cur + W'(1);
        else                return cur;
    endfunction

    function automatic logic model_tc(logic [W-1:0] cur, logic ec);
        return ec && (cur == {W{1'b1}});
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply current inputs at the next edge; outputs are looked at 1 ns later
    task automatic step();
        logic [W-1:0] nxt;
        nxt = model_next(exp_cnt, clr_n, load_n, din, en_par, en_carry);
        @(posedge clk);
        #1;
        exp_cnt = nxt;
    endtask

    task automatic set_in(logic c_n, logic l_n, logic [W-1:0] d, logic ep, logic ec);
        clr_n = c_n; load_n = l_n; din = d; en_par = ep; en_carry = ec;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [CW-1:0] ch_exp;
        void'($urandom(32'd1163));
        set_in(1'b0, 1'b1, 4'd9, 1'b1, 1'b1);
        ch_clr_n = 1'b0; ch_load_n = 1'b1; ch_din = '0; ch_en = 1'b0;
        exp_cnt = '0;
        step(); step();
        // R1: reset state, clear overrides enables
        check("R1 reset count", 16'(count), 16'(0));
        check("R1 reset tc", 16'(tc), 16'(0));

        // R2: preset to 12 with both enables low
        set_in(1'b1, 1'b0, 4'd12, 1'b0, 1'b0);
        step();
        check("R2 preset", 16'(count), 16'(12));
        // R3 / R5: 13, 14, 15, 0
        set_in(1'b1, 1'b1, 4'd3, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3 increment", 16'(count), 16'(exp_cnt));
        end
        check("R3 reached 15", 16'(count), 16'(15));
        check("R6 tc at top", 16'(tc), 16'(1));
        en_par = 1'b0; #1;
        check("R6 tc ignores en_par", 16'(tc), 16'(1));
        step();
        check("R4 hold with en_par low", 16'(count), 16'(15));
        en_carry = 1'b0; #1;
        check("R6 tc follows en_carry", 16'(tc), 16'(0));
        step();
        check("R4 hold with en_carry low", 16'(count), 16'(15));
        en_par = 1'b1; en_carry = 1'b1;
        step();
        check("R5 wrap to zero", 16'(count), 16'(0));
        check("R5 tc after wrap", 16'(tc), 16'(0));

        // R2: preset wins over counting
        set_in(1'b1, 1'b0, 4'd6, 1'b1, 1'b1);
        step();
        check("R2 preset over count", 16'(count), 16'(6));
        // R1: clear wins over preset and count
        set_in(1'b0, 1'b0, 4'd10, 1'b1, 1'b1);
        step();
        check("R1 clear over preset", 16'(count), 16'(0));

        // R8: free run from 13, tc pattern 0,0,1,0,0
        set_in(1'b1, 1'b0, 4'd13, 1'b1, 1'b1);
        step();
        load_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            check("R8 tc one period", 16'(tc), 16'(model_tc(exp_cnt, en_carry)));
            check("R8 count", 16'(count), 16'(exp_cnt));
            step();
        end

        // Random mix checking R1..R6 against the model
        for (int k = 0; k < 3000; k++) begin
            set_in(($urandom % 8) != 0, ($urandom % 5) != 0, W'($urandom),
                   ($urandom % 4) != 0, ($urandom % 4) != 0);
            step();
            check("R1-R4 random count", 16'(count), 16'(exp_cnt));
            check("R6 random tc", 16'(tc), 16'(model_tc(exp_cnt, en_carry)));
        end

        // R7: three-stage chain steps through all 4096 values
        ch_clr_n = 1'b0;
        @(posedge clk); #1;
        check("R7 chain clear", 16'(ch_value), 16'(0));
        ch_clr_n = 1'b1; ch_en = 1'b1;
        ch_exp = '0;
        for (int k = 0; k < (1 << CW) + 2; k++) begin
            check("R7 chain tc", 16'(ch_tc), 16'(ch_exp == {CW{1'b1}}));
            @(posedge clk); #1;
            ch_exp = ch_exp + CW'(1);
            check("R7 chain value", 16'(ch_value), 16'(ch_exp));
        end
        // R7: common enable low freezes every stage
        ch_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check("R7 chain hold", 16'(ch_value), 16'(ch_exp));
        end
        // R7: preset of the chain near the top, then a carry through all stages
        ch_load_n = 1'b0; ch_din = {CW{1'b1}};
        @(posedge clk); #1;
        ch_load_n = 1'b1; ch_en = 1'b1; #1;
        check("R7 chain tc at top", 16'(ch_tc), 16'(1));
        @(posedge clk); #1;
        check("R7 chain full carry", 16'(ch_value), 16'(0));

        summary();
        $finish;
    end

endmodule